// File: doc/BRIEF.md
# LCD Column Scan Output Engine

This block refreshes a 64-column segment display from a bit-mapped display memory, one display row at a time. A frame pulse loads the row counter from a programmable start row, which scrolls the image vertically. After that load, and after every row step, the block reads the coming row from memory through its scan read port. It reads one byte per column and keeps the selected bit in a prefetch buffer.

Each rising edge of the line clock moves the prefetched row into the output register and steps the counter to the next row. Every column output is a 2-bit code that selects one of four drive voltages. The code depends on the latched pixel, the AC-inversion phase and the display-enable flag. A pin can mirror the column order. The frame and line clocks are asynchronous to the system clock. Each one passes through a two-flop synchroniser with rising-edge detection.

Top module: `lcd_col_scan`

## Requirements
- R1: After reset the output register holds all zeros and the row counter is 0. The first line-clock rise with no frame pulse therefore shows row 0.
- R2: A rising edge on `frm_in` loads the row counter from `start_line`. The next line-clock rise then shows that row.
- R3: Each rising edge on `cl_in` latches the prefetched row into the output register and advances the row counter by one.
- R4: The row counter wraps from 63 to 0 without a frame pulse.
- R5: With `disp_on`=1, the level code of a column is: m=1 with pixel 1 gives 2'b00, m=0 with pixel 1 gives 2'b01, m=1 with pixel 0 gives 2'b10, m=0 with pixel 0 gives 2'b11.
- R6: With `disp_on`=0, every column drives a non-selected code whatever the memory holds: 2'b10 when m=1 and 2'b11 when m=0.
- R7: With `col_fwd`=1, column address c drives level slot c (bits 2c+1:2c of `seg_lvl`). With `col_fwd`=0, column address c drives slot 63-c.
- R8: The pixel for row r and column c is bit (r mod 8) of the byte at read address (r/8)*64 + c. Read data returns one cycle after `rd_en`.
- R9: The output register changes only on a line-clock rise. A frame pulse alone, or a change of `start_line`, leaves the outputs unchanged.
- R10: A prefetch starts on every row load or row step and ends after exactly 64 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_in | input | 1 | Frame pulse, asynchronous |
| cl_in | input | 1 | Line clock, asynchronous |
| m_in | input | 1 | AC-inversion phase |
| col_fwd | input | 1 | Column order: 1 forward, 0 mirrored |
| disp_on | input | 1 | Display enable |
| start_line | input | 6 | Row loaded on a frame pulse |
| rd_en | output | 1 | Scan read request |
| rd_addr | output | 9 | Scan read address, {row/8, column} |
| rd_data | input | 8 | Scan read data, one cycle latency |
| seg_lvl | output | 128 | 64 two-bit drive-level codes, slot 0 in bits 1:0 |

## Verification
A wrong row counter shows up at the next line-clock rise as a whole row of level codes that belongs to another row of memory. A scroll or wrap error shows in the same way at the first step after the frame pulse or after row 63. A wrong bit select or column index in the prefetch corrupts single columns, and only in rows that use that bit. Because the output mapping is combinational from the latched row, any error in level coding, mirroring or blanking appears at once when `m_in`, `col_fwd` or `disp_on` change.

// File: rtl/lcd_col_scan.sv
module lcd_col_scan #(
  parameter int COLS   = 64,
  parameter int LINES  = 64,
  parameter int BYTE_W = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        frm_in,
  input  logic                                        cl_in,
  input  logic                                        m_in,
  input  logic                                        col_fwd,
  input  logic                                        disp_on,
  input  logic [$clog2(LINES)-1:0]                    start_line,
  output logic                                        rd_en,
  output logic [$clog2(LINES)-$clog2(BYTE_W)+$clog2(COLS)-1:0] rd_addr,
  input  logic [BYTE_W-1:0]                           rd_data,
  output logic [2*COLS-1:0]                           seg_lvl
);
  localparam int CW = $clog2(COLS);
  localparam int LW = $clog2(LINES);
  localparam int SW = $clog2(BYTE_W);

  logic [2:0] frm_sy, cl_sy;
  logic [LW-1:0] lcnt;
  logic [COLS-1:0] line_q, pbuf;
  logic busy, rv;
  logic [CW-1:0] fcnt, rcol;
  logic [SW-1:0] rsel;

  wire frm_rise = frm_sy[1] & ~frm_sy[2];
  wire cl_rise  = cl_sy[1] & ~cl_sy[2];
  wire trig     = frm_rise | cl_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frm_sy <= '0;
      cl_sy  <= '0;
    end else begin
      frm_sy <= {frm_sy[1:0], frm_in};
      cl_sy  <= {cl_sy[1:0], cl_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcnt   <= '0;
      line_q <= '0;
    end else begin
      if (cl_rise) line_q <= pbuf;
      if (frm_rise) lcnt <= start_line;
      else if (cl_rise) lcnt <= (lcnt == LW'(LINES-1)) ? '0 : lcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b1;
      fcnt <= '0;
      rv   <= 1'b0;
      rcol <= '0;
      rsel <= '0;
      pbuf <= '0;
    end else begin
      if (trig) begin
        busy <= 1'b1;
        fcnt <= '0;
      end else if (busy) begin
        if (fcnt == CW'(COLS-1)) busy <= 1'b0;
        else fcnt <= fcnt + 1'b1;
      end
      rv   <= busy & ~trig;
      rcol <= fcnt;
      rsel <= lcnt[SW-1:0];
      if (rv) pbuf[rcol] <= rd_data[rsel];
    end

  assign rd_en   = busy;
  assign rd_addr = {lcnt[LW-1:SW], fcnt};

  for (genvar j = 0; j < COLS; j++) begin : g_col
    wire d = col_fwd ? line_q[j] : line_q[COLS-1-j];
    assign seg_lvl[2*j +: 2] = {~(d & disp_on), ~m_in};
  end

  // R2
  frm_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rise |=> lcnt == $past(start_line));

  // R3
  cl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_rise && !frm_rise && lcnt != LW'(LINES-1)) |=> lcnt == $past(lcnt) + 1'b1);

  // R4
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_rise && !frm_rise && lcnt == LW'(LINES-1)) |=> lcnt == '0);

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_rise |=> $stable(line_q));

  // R10
  fetch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fcnt == CW'(COLS-1) && !trig) |=> !rd_en);

  // R10
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (rd_en && rd_addr[CW-1:0] == '0));
endmodule

// File: tb/sim_lcd_col_scan.sv
module sim_lcd_col_scan;
  logic clk = 0, rst_n = 0;
  logic frm_in = 0, cl_in = 0, m_in = 1, col_fwd = 1, disp_on = 1;
  logic [5:0] start_line = '0;
  logic rd_en;
  logic [8:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [127:0] seg_lvl;
  int n_run = 0, n_fail = 0;

  lcd_col_scan u0 (.clk, .rst_n, .frm_in, .cl_in, .m_in, .col_fwd, .disp_on,
                   .start_line, .rd_en, .rd_addr, .rd_data, .seg_lvl);

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) ^ (a >> 3) ^ 8'h5A);
  endfunction

  function automatic logic pix(input int r, input int c);
    logic [7:0] b;
    b = pat((r / 8) * 64 + c);
    return b[r % 8];
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= pat(int'(rd_addr));

  task automatic pulse(input bit frame);
    @(negedge clk);
    if (frame) frm_in = 1; else cl_in = 1;
    repeat (6) @(negedge clk);
    frm_in = 0; cl_in = 0;
    repeat (90) @(negedge clk);
  endtask

  task automatic chk_row(input int r, input bit zeros, input string tag);
    for (int on = 0; on < 2; on++)
      for (int fw = 0; fw < 2; fw++)
        for (int m = 0; m < 2; m++) begin
          string rq;
          bit bad;
          disp_on = on[0]; col_fwd = fw[0]; m_in = m[0];
          #1;
          rq = (on == 0) ? "R6" : (fw == 0) ? "R7" : "R5";
          bad = 0;
          n_run++;
          for (int j = 0; j < 64 && !bad; j++) begin
            int c;
            logic d;
            logic [1:0] e;
            c = fw ? j : 63 - j;
            d = zeros ? 1'b0 : pix(r, c);
            e = {~(d & on[0]), ~m[0]};
            if (seg_lvl[2*j +: 2] !== e) begin
              bad = 1;
              n_fail++;
              $display("FAIL %s/%s row %0d on=%0d fwd=%0d m=%0d slot %0d: got %b exp %b",
                       tag, rq, r, on, fw, m, j, seg_lvl[2*j +: 2], e);
            end
          end
        end
    disp_on = 1; col_fwd = 1; m_in = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cur;
    int starts[5] = '{5, 8, 63, 37, 20};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (80) @(negedge clk);
    chk_row(0, 1, "R1");
    pulse(0); chk_row(0, 0, "R1");
    pulse(0); chk_row(1, 0, "R3");
    cur = 1;
    foreach (starts[i]) begin
      int s;
      s = starts[i];
      start_line = 6'(s);
      pulse(1);
      chk_row(cur, 0, "R9");
      start_line = 6'(s ^ 6'h2A);
      pulse(0); chk_row(s, 0, "R2");
      pulse(0); chk_row((s + 1) % 64, 0, (s == 63) ? "R4" : "R3");
      repeat (150) @(negedge clk);
      chk_row((s + 1) % 64, 0, "R9");
      cur = (s + 1) % 64;
    end
    start_line = 0;
    pulse(1);
    for (int r = 0; r <= 64; r++) begin
      pulse(0);
      chk_row(r % 64, 0, (r == 64) ? "R4" : "R8");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule